// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one 32-bit single-precision value by another and returns the 32-bit quotient. The two operands arrive on separate ports, and each port has its own load strobe. The dividend and the divisor can be loaded in the same cycle or in different cycles. A division begins once both operands have been loaded since the previous division started. The quotient then appears on a registered output together with a one-cycle valid strobe and a divide-by-zero flag.

Internally the operands are split into sign, exponent and fraction. The result sign is the exclusive-or of the two operand signs. The biased exponent difference is formed with two guard bits. The two 24-bit mantissas, each with its leading one restored, go to a restoring shift-subtract divider. That divider yields one quotient bit per clock and 25 bits in all. A normalize stage then picks the fraction from the raw quotient, adjusts the exponent, and clamps the result to zero or infinity. A zero-detect unit classifies each operand. Any operand whose exponent field is zero is treated as zero, so denormals are flushed. Inputs with an all-ones exponent are handled as ordinary numbers. Fractions are truncated, not rounded.

Top module: `fp32_div`

## Requirements
- R1: Result bit 31 (the sign) equals bit 31 of the dividend exclusive-or bit 31 of the divisor, for every kind of result, zero and infinity included.
- R2: An operand register takes its input only while the block is idle and no division is starting in that cycle. A division starts in the cycle after both operands have been loaded since the last start. A second load of the same operand before the other one arrives replaces the first. Loads that arrive from the start cycle through the cycle before the result strobe have no effect. This covers a load in the divider's final cycle.
- R3: `q_valid` goes high exactly 27 clock edges after the edge that completes the operand loads, and it stays high for exactly one cycle.
- R4: For normal operands, let Ma be the dividend mantissa and Mb the divisor mantissa, each with its hidden one restored (24 bits). Let Q = floor(Ma·2^24 / Mb), a 25-bit value. If Q bit 24 is 1, the fraction is Q bits 23..1 and the exponent field is ea − eb + 127. Otherwise the fraction is Q bits 22..0 and the exponent field is ea − eb + 126. Example: 0x41FAEF9E / 0xBEAE147B = 0xC2B88303.
- R5: A divisor whose exponent field (bits 30..23) is zero produces an infinity: exponent field all ones, fraction zero, sign per R1. `div_zero` is set to 1. This applies whatever the dividend is.
- R6: A dividend whose exponent field is zero, divided by a divisor with a nonzero exponent field, gives a signed zero (bits 30..0 all zero), with `div_zero` 0.
- R7: When the adjusted exponent of R4 is 0 or below, the result is a signed zero.
- R8: When the adjusted exponent of R4 is 255 or above, the result is a signed infinity, with `div_zero` 0.
- R9: After reset, `q_out`, `q_valid` and `div_zero` are 0. `q_out` and `div_zero` keep their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 32 | Dividend operand |
| a_load | input | 1 | Load strobe for the dividend |
| b_in | input | 32 | Divisor operand |
| b_load | input | 1 | Load strobe for the divisor |
| q_out | output | 32 | Registered quotient |
| q_valid | output | 1 | One-cycle strobe marking a new quotient |
| div_zero | output | 1 | Set with the quotient when the divisor was zero |

## Verification
The operand capture logic and the result path can be active in the same cycle in two ways. In the first, a fresh pair of operands is driven in the very cycle the result strobe is high. The block is idle by then, so that pair must start a second division, and its result must appear 27 edges later. In the second, operands are driven in the divider's last cycle, one clock before the strobe. That pair must be dropped: the first result must be unaffected, and no second strobe may follow over a long quiet window. In both cases each quotient is compared with a value the bench computes by integer division of the restored mantissas.

// File: rtl/fpdiv_pkg.sv
`timescale 1ns/1ps
package fpdiv_pkg;
  typedef enum logic {ST_IDLE, ST_DIV} div_state_e;
  typedef enum logic [1:0] {K_NUM, K_ZERO, K_INF} res_kind_e;
endpackage

// File: rtl/fpdiv_zero_chk.sv
`timescale 1ns/1ps
module fpdiv_zero_chk #(
  parameter int EXP_W = 8
) (
  input  logic [EXP_W-1:0] exp_field,
  output logic             is_zero
);
  // A zero exponent field marks zero or a denormal; both are treated as zero.
  assign is_zero = (exp_field == '0);
endmodule

// File: rtl/fpdiv_mant_div.sv
`timescale 1ns/1ps
module fpdiv_mant_div #(
  parameter  int MAN_W = 24,
  localparam int QW    = MAN_W + 1,
  localparam int CW    = $clog2(QW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [MAN_W-1:0] dividend,
  input  logic [MAN_W-1:0] divisor,
  output logic [QW-1:0]    quo,
  output logic             done
);
  logic [MAN_W:0]   rem;
  logic [MAN_W-1:0] dvs;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic [MAN_W+1:0] diff;
  logic             take;
  logic [MAN_W:0]   rem_next;

  assign diff     = {1'b0, rem} - {2'b00, dvs};
  assign take     = ~diff[MAN_W+1];
  assign rem_next = take ? diff[MAN_W:0] : rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      quo  <= '0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= {1'b0, dividend};
      dvs  <= divisor;
      cnt  <= CW'(QW);
      busy <= 1'b1;
      quo  <= '0;
      done <= 1'b0;
    end else if (busy) begin
      quo  <= {quo[QW-2:0], take};
      rem  <= {rem_next[MAN_W-1:0], 1'b0};
      cnt  <= cnt - CW'(1);
      busy <= (cnt != CW'(1));
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  // The partial remainder must stay below twice the divisor, else a quotient bit is lost.
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < {dvs, 1'b0}));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fpdiv_norm.sv
`timescale 1ns/1ps
module fpdiv_norm import fpdiv_pkg::*; #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int QW     = FRAC_W + 2,
  localparam int EW     = EXP_W + 2,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [QW-1:0]        quo,
  input  logic                 sign,
  input  res_kind_e            kind,
  input  logic                 dz,
  input  logic signed [EW-1:0] exp_in,
  output logic [WORD_W-1:0]    q_out,
  output logic                 q_valid,
  output logic                 div_zero
);
  localparam logic signed [EW-1:0] E_ZERO = '0;
  localparam logic signed [EW-1:0] E_ONE  = EW'(1);
  localparam logic signed [EW-1:0] E_MAX  = EW'((1 << EXP_W) - 1);

  logic                 top;
  logic [FRAC_W-1:0]    frac;
  logic signed [EW-1:0] e_adj;
  logic [WORD_W-1:0]    packed_res;

  assign top   = quo[QW-1];
  assign frac  = top ? quo[QW-2:1] : quo[QW-3:0];
  assign e_adj = top ? exp_in : (exp_in - E_ONE);

  always_comb begin
    packed_res = {sign, {(WORD_W-1){1'b0}}};
    case (kind)
      K_INF:  packed_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_ZERO: packed_res = {sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (e_adj <= E_ZERO)
          packed_res = {sign, {(WORD_W-1){1'b0}}};
        else if (e_adj >= E_MAX)
          packed_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
          packed_res = {sign, e_adj[EXP_W-1:0], frac};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out    <= '0;
      q_valid  <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_out    <= packed_res;
        div_zero <= dz;
      end
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> !q_valid);

  assert_dz_gives_inf_R5: assert property (@(posedge clk) disable iff (rst)
    (q_valid && div_zero) |-> (q_out[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_out_held_R9: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> ($stable(q_out) && $stable(div_zero)));
endmodule

// File: rtl/fp32_div.sv
`timescale 1ns/1ps
module fp32_div import fpdiv_pkg::*; #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_in,
  input  logic              a_load,
  input  logic [WORD_W-1:0] b_in,
  input  logic              b_load,
  output logic [WORD_W-1:0] q_out,
  output logic              q_valid,
  output logic              div_zero
);
  localparam int MAN_W = FRAC_W + 1;
  localparam int QW    = MAN_W + 1;
  localparam int EW    = EXP_W + 2;
  localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (EXP_W - 1)) - 1);

  div_state_e           state;
  logic [WORD_W-1:0]    a_reg, b_reg;
  logic                 a_pend, b_pend;
  logic                 start, accept;
  logic [WORD_W-1:0]    opnd [2];
  logic [1:0]           zero_flag;
  logic signed [EW-1:0] exp_calc;
  logic                 sign_r, dz_r;
  res_kind_e            kind_r;
  logic signed [EW-1:0] exp_r;
  logic [QW-1:0]        quo;
  logic                 div_done;

  assign opnd[0] = a_reg;
  assign opnd[1] = b_reg;

  for (genvar g = 0; g < 2; g++) begin : g_zchk
    fpdiv_zero_chk #(.EXP_W(EXP_W)) u_zchk (
      .exp_field (opnd[g][WORD_W-2 -: EXP_W]),
      .is_zero   (zero_flag[g])
    );
  end

  assign start    = (state == ST_IDLE) && a_pend && b_pend;
  assign accept   = (state == ST_IDLE) && !start;
  assign exp_calc = $signed({2'b00, a_reg[WORD_W-2 -: EXP_W]})
                  - $signed({2'b00, b_reg[WORD_W-2 -: EXP_W]}) + BIAS_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      a_reg  <= '0;
      b_reg  <= '0;
      a_pend <= 1'b0;
      b_pend <= 1'b0;
      sign_r <= 1'b0;
      dz_r   <= 1'b0;
      kind_r <= K_NUM;
      exp_r  <= '0;
    end else begin
      if (accept && a_load) begin
        a_reg  <= a_in;
        a_pend <= 1'b1;
      end
      if (accept && b_load) begin
        b_reg  <= b_in;
        b_pend <= 1'b1;
      end
      if (start) begin
        state  <= ST_DIV;
        a_pend <= 1'b0;
        b_pend <= 1'b0;
        sign_r <= a_reg[WORD_W-1] ^ b_reg[WORD_W-1];
        exp_r  <= exp_calc;
        dz_r   <= zero_flag[1];
        if (zero_flag[1])      kind_r <= K_INF;
        else if (zero_flag[0]) kind_r <= K_ZERO;
        else                   kind_r <= K_NUM;
      end else if ((state == ST_DIV) && div_done) begin
        state <= ST_IDLE;
      end
    end
  end

  fpdiv_mant_div #(.MAN_W(MAN_W)) u_mdiv (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dividend ({1'b1, a_reg[FRAC_W-1:0]}),
    .divisor  ({1'b1, b_reg[FRAC_W-1:0]}),
    .quo      (quo),
    .done     (div_done)
  );

  fpdiv_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (div_done),
    .quo      (quo),
    .sign     (sign_r),
    .kind     (kind_r),
    .dz       (dz_r),
    .exp_in   (exp_r),
    .q_out    (q_out),
    .q_valid  (q_valid),
    .div_zero (div_zero)
  );

  assert_busy_ignores_load_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV) |=> ($stable(a_reg) && $stable(b_reg)));

  assert_sign_xor_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (sign_r == ($past(a_in[WORD_W-1] & 1'b0) | ($past(a_reg[WORD_W-1]) ^ $past(b_reg[WORD_W-1])))));
endmodule

// File: tb/sim_fp32_div.sv
`timescale 1ns/1ps
module sim_fp32_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0, b_in = '0;
  logic        a_load = 1'b0, b_load = 1'b0;
  logic [31:0] q_out;
  logic        q_valid, div_zero;
  int          nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  fp32_div u0 (.clk(clk), .rst(rst), .a_in(a_in), .a_load(a_load), .b_in(b_in),
               .b_load(b_load), .q_out(q_out), .q_valid(q_valid), .div_zero(div_zero));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e;
    longint ma, mb, q;
    logic [22:0] f;
    s = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (eb == 0) return {1'b1, s, 8'hFF, 23'd0};
    if (ea == 0) return {1'b0, s, 31'd0};
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    q = (ma << 24) / mb;
    e = ea - eb + 127;
    if (q >= (longint'(1) << 24)) f = 23'((q >> 1) & 64'h7FFFFF);
    else begin f = 23'(q & 64'h7FFFFF); e = e - 1; end
    if (e <= 0) return {1'b0, s, 31'd0};
    if (e >= 255) return {1'b0, s, 8'hFF, 23'd0};
    return {1'b0, s, 8'(e), f};
  endfunction

  function automatic string tag_of(input logic [32:0] r);
    if (r[32]) return "R5";
    if (r[30:23] == 8'hFF) return "R8";
    if (r[30:0] == 31'd0) return "R7/R6";
    return "R4";
  endfunction

  function automatic logic [22:0] frac_pat(input int i);
    if (i == 0) return 23'd0;
    if (i == 1) return 23'h7FFFFF;
    return 23'((i * 32'h9E3779B1) >> 7);
  endfunction

  function automatic logic [15:0] exp_pair(input int k);
    case (k)
      0: return {8'd127, 8'd127};
      1: return {8'd131, 8'd125};
      2: return {8'd254, 8'd127};
      3: return {8'd1,   8'd127};
      4: return {8'd200, 8'd60};
      5: return {8'd20,  8'd220};
      default: return {8'd128, 8'd1};
    endcase
  endfunction

  // Called at a falling edge: drives both operands for one rising edge.
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    a_in = a; b_in = b; a_load = 1'b1; b_load = 1'b1;
    @(negedge clk);
    a_load = 1'b0; b_load = 1'b0;
  endtask

  task automatic wait_res(inout int cnt);
    while (!q_valid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [32:0] ev, input string req);
    int cnt = 0;
    launch(a, b);
    wait_res(cnt);
    chk("R3 latency", 64'(cnt), 64'd27);
    chk(req, 64'(q_out), 64'(ev[31:0]));
    chk({req, " div_zero"}, 64'(div_zero), 64'(ev[32]));
    chk("R1 sign", 64'(q_out[31]), 64'(a[31] ^ b[31]));
    @(negedge clk);
    chk("R3 one-cycle strobe", 64'(q_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int cnt, nv;
    logic [31:0] a, b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset q_out", 64'(q_out), 64'd0);
    chk("R9 reset q_valid", 64'(q_valid), 64'd0);
    chk("R9 reset div_zero", 64'(div_zero), 64'd0);

    // R4 worked example
    run(32'h41FAEF9E, 32'hBEAE147B, {1'b0, 32'hC2B88303}, "R4 example");
    // R5 zero or denormal divisor
    run(32'h40000000, 32'h00000000, {1'b1, 32'h7F800000}, "R5 +x/+0");
    run(32'hC0000000, 32'h80000000, {1'b1, 32'h7F800000}, "R5 -x/-0");
    run(32'h00000000, 32'h80000000, {1'b1, 32'hFF800000}, "R5 0/-0");
    run(32'h3F800000, 32'h00012345, {1'b1, 32'h7F800000}, "R5 denormal divisor");
    // R6 zero or denormal dividend
    run(32'h80000000, 32'h3F800000, {1'b0, 32'h80000000}, "R6 -0/1");
    run(32'h00400000, 32'hBF800000, {1'b0, 32'h80000000}, "R6 denormal dividend");
    // R7 / R8 boundaries
    run(32'h00800000, 32'h3F800001, {1'b0, 32'h00000000}, "R7 underflow edge");
    run(32'h7F7FFFFF, 32'h3F000000, {1'b0, 32'h7F800000}, "R8 overflow");
    run(32'h7F000000, 32'h3F800000, {1'b0, 32'h7F000000}, "R4 largest exp kept");

    // Sweep over exponent pairs, fraction patterns and signs
    for (int k = 0; k < 7; k++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          logic [15:0] ep;
          ep = exp_pair(k);
          a = {1'(ia), ep[15:8], frac_pat(ia + 3 * k)};
          b = {1'(ib >> 1), ep[7:0], frac_pat(ib + 5 * k + 1)};
          run(a, b, model(a, b), tag_of(model(a, b)));
        end
      end
    end

    // R2: loads in the middle of a division are ignored
    launch(32'h40490FDB, 32'h402DF854);
    repeat (10) @(negedge clk);
    a_in = 32'h3F800000; b_in = 32'h40000000; a_load = 1'b1; b_load = 1'b1;
    @(negedge clk);
    a_load = 1'b0; b_load = 1'b0;
    cnt = 11;
    wait_res(cnt);
    chk("R2 mid-division load latency", 64'(cnt), 64'd27);
    chk("R2 mid-division load ignored", 64'(q_out), 64'(model(32'h40490FDB, 32'h402DF854)));
    nv = 0;
    repeat (60) begin @(negedge clk); if (q_valid) nv++; end
    chk("R2 no extra division", 64'(nv), 64'd0);

    // R2: load in the divider's final cycle is dropped; R9 output held
    launch(32'hC1200000, 32'h40400000);
    repeat (26) @(negedge clk);
    a_in = 32'h3F000000; b_in = 32'h3E800000; a_load = 1'b1; b_load = 1'b1;
    @(negedge clk);
    a_load = 1'b0; b_load = 1'b0;
    chk("R3 strobe at 27", 64'(q_valid), 64'd1);
    chk("R2 final-cycle load result", 64'(q_out), 64'(model(32'hC1200000, 32'h40400000)));
    nv = 0;
    repeat (60) begin @(negedge clk); if (q_valid) nv++; end
    chk("R2 final-cycle load ignored", 64'(nv), 64'd0);
    chk("R9 q_out held", 64'(q_out), 64'(model(32'hC1200000, 32'h40400000)));

    // R2: operands loaded separately, dividend replaced before divisor arrives
    a_in = 32'h41000000; a_load = 1'b1;
    @(negedge clk); a_load = 1'b0;
    a_in = 32'h42C80000; a_load = 1'b1;
    @(negedge clk); a_load = 1'b0;
    nv = 0;
    repeat (40) begin @(negedge clk); if (q_valid) nv++; end
    chk("R2 one operand does not start", 64'(nv), 64'd0);
    b_in = 32'h40E00000; b_load = 1'b1;
    @(negedge clk); b_load = 1'b0;
    cnt = 0;
    wait_res(cnt);
    chk("R3 latency after divisor load", 64'(cnt), 64'd27);
    chk("R2 latest dividend used", 64'(q_out), 64'(model(32'h42C80000, 32'h40E00000)));
    @(negedge clk);

    // Load landing in the strobe cycle starts the next division
    launch(32'h3FC00000, 32'h3F400000);
    cnt = 0;
    wait_res(cnt);
    chk("R4 first of back-to-back", 64'(q_out), 64'(model(32'h3FC00000, 32'h3F400000)));
    launch(32'hBDCCCCCD, 32'h3EAAAAAB);
    cnt = 0;
    wait_res(cnt);
    chk("R2 load in strobe cycle accepted", 64'(cnt), 64'd27);
    chk("R4 second of back-to-back", 64'(q_out), 64'(model(32'hBDCCCCCD, 32'h3EAAAAAB)));

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule